// File: doc/BRIEF.md
# Nyquist Zone Frequency Folder

This block turns a requested tuning frequency, which may sit many sample-rate multiples above baseband, into the signed frequency that a numerically controlled oscillator actually runs at, plus the fixed-point frequency word for that oscillator. The caller presents an unsigned target frequency and the sample rate, both as integers in the same unit, on a valid/ready handshake. The block strips every whole multiple of the sample rate with a serial shift-and-subtract unit. It then decides whether the remainder falls in an odd or an even Nyquist zone and folds it into the band from minus half to plus half the sample rate.

The folded value is scaled to a 48-bit two's-complement word equal to the folded frequency times 2^48 divided by the sample rate. A second serial restoring divider does the scaling, one quotient bit per clock. The result is held on an output valid/ready handshake. A sample rate of zero is refused with a one-cycle error pulse and yields no result.

Top module: `nzf_folder`

## Requirements
- R1: After reset, and after a reset that interrupts a calculation, `in_ready` is 1 and `busy`, `out_valid` and `err_zero_fs` are 0.
- R2: For an accepted request with a nonzero sample rate, the result uses the remainder r = target mod fs, which lies in [0, fs).
- R3: When 2*r < fs (odd zone), `out_even_zone` is 0 and `out_fold` equals +r.
- R4: When 2*r >= fs (even zone, including the exact half-rate point), `out_even_zone` is 1 and `out_fold` equals r - fs, a negative value no lower than -fs/2.
- R5: `out_word` is floor(|fold| * 2^48 / fs) with the sign of the fold, as a 48-bit two's-complement value. Bit 47 equals `out_even_zone`, and the half-rate point gives 0x800000000000.
- R6: From the cycle after a request is accepted until the result appears, `busy` is 1 and `in_ready` is 0.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_fold`, `out_even_zone` and `out_word` stay unchanged. One cycle after the result is taken, `out_valid` is 0 and `in_ready` is 1.
- R8: A request accepted with fs = 0 makes `err_zero_fs` 1 for exactly the next cycle. It starts no calculation and never raises `out_valid`.
- R9: A target that is an exact multiple of fs, including zero, gives an odd-zone result with fold 0 and word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| in_target | input | FW | Unsigned target frequency |
| in_fs | input | FW | Unsigned sample rate |
| busy | output | 1 | Calculation in progress |
| err_zero_fs | output | 1 | One-cycle pulse: request refused, fs was zero |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Result taken by the consumer |
| out_fold | output | FW+1 | Signed folded frequency |
| out_even_zone | output | 1 | 1 when the target lay in an even Nyquist zone |
| out_word | output | 48 | Signed oscillator frequency word |

## Verification
A fixed set of target and rate pairs drives the fold: targets inside the first zone, targets several zones up on each side of the half-rate point, the exact half-rate point for an even rate, and the points either side of it for an odd rate. Each pair separates a wrong zone decision, a missing or extra subtraction of fs, and a wrong sign or rounding of the word. Exact multiples and a zero target test the zero result. Extreme 32-bit values test the full-width remainder and divider paths. Random pairs checked against an arbitrary-precision model in the bench cover the remaining space, and directed runs cover output stalls, a zero rate and a reset in mid-calculation.

// File: rtl/nzf_pkg.sv
package nzf_pkg;

    localparam int NZF_WORD_W = 48;
    localparam int NZF_FW_DEF = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOD  = 2'd1,
        ST_DIV  = 2'd2,
        ST_HOLD = 2'd3
    } nzf_state_e;

    // Per-request record captured after the fold step.
    typedef struct packed {
        logic even;
    } nzf_zone_t;

endpackage

// File: rtl/nzf_serial_div.sv
// Serial restoring divider: shifts the dividend bits one per clock into a
// partial remainder seeded with init_rem (which must be below divisor).
module nzf_serial_div #(
    parameter int RW = 32,
    parameter int DW = 32,
    localparam int CW = (DW > 1) ? $clog2(DW) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [RW-1:0] init_rem,
    input  logic [DW-1:0] dividend,
    input  logic [RW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] quot,
    output logic [RW-1:0] rem
);
    logic [RW-1:0] rem_q;
    logic [DW-1:0] dvd_q;
    logic [DW-1:0] quot_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          done_q;

    logic [RW:0]   trial;
    logic [RW:0]   diff;
    logic          ge;

    always_comb begin
        trial = {rem_q, dvd_q[DW-1]};
        ge    = trial >= {1'b0, divisor};
        diff  = trial - {1'b0, divisor};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            done_q <= 1'b0;
            rem_q  <= '0;
            dvd_q  <= '0;
            quot_q <= '0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q  <= init_rem;
                dvd_q  <= dividend;
                quot_q <= '0;
                cnt_q  <= CW'(DW - 1);
                run_q  <= 1'b1;
            end else if (run_q) begin
                rem_q  <= ge ? diff[RW-1:0] : trial[RW-1:0];
                dvd_q  <= {dvd_q[DW-2:0], 1'b0};
                quot_q <= {quot_q[DW-2:0], ge};
                if (cnt_q == '0) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign busy = run_q;
    assign done = done_q;
    assign quot = quot_q;
    assign rem  = rem_q;
endmodule

// File: rtl/nzf_fold.sv
// Zone decision and fold of a reduced remainder r in [0, fs).
module nzf_fold #(
    parameter int FW = 32
) (
    input  logic                 [FW-1:0] rem,
    input  logic                 [FW-1:0] fs,
    output logic                          even,
    output logic                 [FW-1:0] mag,
    output logic signed          [FW:0]   fold
);
    always_comb begin
        even = {rem, 1'b0} >= {1'b0, fs};
        mag  = even ? (fs - rem) : rem;
        fold = even ? ($signed({1'b0, rem}) - $signed({1'b0, fs}))
                    : $signed({1'b0, rem});
    end
endmodule

// File: rtl/nzf_folder.sv
module nzf_folder
    import nzf_pkg::*;
#(
    parameter int FW = NZF_FW_DEF,
    localparam int WW = NZF_WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [FW-1:0]        in_target,
    input  logic [FW-1:0]        in_fs,
    output logic                 busy,
    output logic                 err_zero_fs,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic signed [FW:0]   out_fold,
    output logic                 out_even_zone,
    output logic [WW-1:0]        out_word
);
    nzf_state_e           st_q;
    logic [FW-1:0]        fs_q;
    logic                 err_q;
    nzf_zone_t            zone_q;
    logic signed [FW:0]   fold_q;
    logic [WW-1:0]        word_q;

    logic                 accept;
    logic                 mod_start, mod_busy, mod_done;
    logic [FW-1:0]        mod_quot, mod_rem;
    logic                 div_busy, div_done;
    logic [WW-1:0]        div_quot;
    logic [FW-1:0]        div_rem;
    logic                 f_even;
    logic [FW-1:0]        f_mag;
    logic signed [FW:0]   f_fold;

    assign accept    = in_valid && (st_q == ST_IDLE);
    assign mod_start = accept && (in_fs != '0);

    nzf_serial_div #(.RW(FW), .DW(FW)) u_mod (
        .clk(clk), .rst(rst), .start(mod_start),
        .init_rem('0), .dividend(in_target), .divisor(fs_q),
        .busy(mod_busy), .done(mod_done), .quot(mod_quot), .rem(mod_rem)
    );

    nzf_fold #(.FW(FW)) u_fold (
        .rem(mod_rem), .fs(fs_q), .even(f_even), .mag(f_mag), .fold(f_fold)
    );

    nzf_serial_div #(.RW(FW), .DW(WW)) u_scale (
        .clk(clk), .rst(rst), .start(mod_done),
        .init_rem(f_mag), .dividend('0), .divisor(fs_q),
        .busy(div_busy), .done(div_done), .quot(div_quot), .rem(div_rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            fs_q   <= '0;
            err_q  <= 1'b0;
            zone_q <= '0;
            fold_q <= '0;
            word_q <= '0;
        end else begin
            err_q <= accept && (in_fs == '0);
            case (st_q)
                ST_IDLE: begin
                    if (mod_start) begin
                        fs_q <= in_fs;
                        st_q <= ST_MOD;
                    end
                end
                ST_MOD: begin
                    if (mod_done) begin
                        zone_q.even <= f_even;
                        fold_q      <= f_fold;
                        st_q        <= ST_DIV;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        word_q <= zone_q.even ? (WW'(0) - div_quot) : div_quot;
                        st_q   <= ST_HOLD;
                    end
                end
                default: begin
                    if (out_ready) st_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign in_ready      = (st_q == ST_IDLE);
    assign busy          = (st_q == ST_MOD) || (st_q == ST_DIV);
    assign err_zero_fs   = err_q;
    assign out_valid     = (st_q == ST_HOLD);
    assign out_fold      = fold_q;
    assign out_even_zone = zone_q.even;
    assign out_word      = word_q;
endmodule

// File: rtl/nzf_chk.sv
module nzf_chk #(
    parameter int FW = 32,
    parameter int WW = 48
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_ready,
    input logic [FW-1:0]       in_fs,
    input logic                busy,
    input logic                err_zero_fs,
    input logic                out_valid,
    input logic                out_ready,
    input logic signed [FW:0]  out_fold,
    input logic                out_even_zone,
    input logic [WW-1:0]       out_word
);
    // R6
    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready && !out_valid);

    // R6
    p_accept_busy_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (in_fs != '0) |=> busy);

    // R7
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_word)
            && $stable(out_fold) && $stable(out_even_zone));

    // R7
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready |=> !out_valid && in_ready);

    // R8
    p_zero_fs_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (in_fs == '0) |=> err_zero_fs && !busy && in_ready);

    // R5
    p_word_sign_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_word[WW-1] == out_even_zone);

    // R4
    p_fold_sign_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_fold[FW] == out_even_zone);
endmodule

bind nzf_folder nzf_chk #(.FW(FW), .WW(WW)) u_nzf_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_fs(in_fs), .busy(busy), .err_zero_fs(err_zero_fs),
    .out_valid(out_valid), .out_ready(out_ready), .out_fold(out_fold),
    .out_even_zone(out_even_zone), .out_word(out_word)
);

// File: tb/nzf_folder_test.sv
module nzf_folder_test;
    localparam int FW = 32;
    localparam int WW = 48;
    localparam int NV = 14;

    localparam logic [FW-1:0] V_TGT [NV] = '{
        32'd1000, 32'd1150, 32'd450, 32'd0, 32'd600, 32'd299, 32'd149,
        32'd150, 32'd151, 32'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
        32'd123456789, 32'hFFFF_FFFE
    };
    localparam logic [FW-1:0] V_FS [NV] = '{
        32'd300, 32'd300, 32'd300, 32'd300, 32'd300, 32'd300, 32'd301,
        32'd301, 32'd301, 32'd1, 32'hFFFF_FFFF, 32'd7,
        32'd1000000, 32'hFFFF_FFFF
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic [FW-1:0]       in_target = '0;
    logic [FW-1:0]       in_fs = '0;
    logic                busy;
    logic                err_zero_fs;
    logic                out_valid;
    logic                out_ready = 1'b0;
    logic signed [FW:0]  out_fold;
    logic                out_even_zone;
    logic [WW-1:0]       out_word;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic signed [FW:0]  e_fold;
    logic                e_even;
    logic [WW-1:0]       e_word;

    always #2 clk = ~clk;

    nzf_folder #(.FW(FW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_target(in_target), .in_fs(in_fs), .busy(busy),
        .err_zero_fs(err_zero_fs), .out_valid(out_valid),
        .out_ready(out_ready), .out_fold(out_fold),
        .out_even_zone(out_even_zone), .out_word(out_word)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: run hung, act=%0d exp<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    // Arbitrary-precision reference for R2..R5.
    task automatic model(input logic [FW-1:0] t, input logic [FW-1:0] f);
        logic [FW-1:0]  r;
        logic [FW-1:0]  m;
        logic [127:0]   num;
        logic [127:0]   q;
        r      = t % f;
        e_even = ({1'b0, r, 1'b0} >= {2'b0, f});
        m      = e_even ? (f - r) : r;
        e_fold = e_even ? ($signed({1'b0, r}) - $signed({1'b0, f})) : $signed({1'b0, r});
        num    = {32'b0, 48'b0, m} << 48;
        q      = num / {96'b0, f};
        e_word = e_even ? (WW'(0) - q[WW-1:0]) : q[WW-1:0];
    endtask

    task automatic run_op(input logic [FW-1:0] t, input logic [FW-1:0] f, input int hold);
        int n;
        logic [WW-1:0] w0;
        model(t, f);
        @(negedge clk);
        in_target = t;
        in_fs     = f;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(busy && !in_ready, "R6 busy after accept", {62'b0, busy, in_ready}, 64'h2);
        n = 0;
        while (!out_valid && n < 400) begin
            @(negedge clk);
            if (!out_valid) chk(busy && !in_ready, "R6 busy while running",
                                {62'b0, busy, in_ready}, 64'h2);
            n++;
        end
        chk(out_valid, "R2 result produced", 64'(out_valid), 64'h1);
        if (e_even)
            chk(out_even_zone && out_fold == e_fold, "R4 even fold",
                64'($signed(out_fold)), 64'($signed(e_fold)));
        else
            chk(!out_even_zone && out_fold == e_fold, "R3 odd fold",
                64'($signed(out_fold)), 64'($signed(e_fold)));
        chk(out_word == e_word, "R5 word", 64'(out_word), 64'(e_word));
        if (t % f == 0)
            chk(out_fold == 0 && out_word == 0 && !out_even_zone, "R9 multiple",
                64'(out_word), 64'h0);
        if (hold > 0) begin
            w0 = out_word;
            repeat (hold) @(negedge clk);
            chk(out_valid && out_word == w0, "R7 held under stall", 64'(out_word), 64'(w0));
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(!out_valid && in_ready, "R7 released", {62'b0, out_valid, in_ready}, 64'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready && !busy && !out_valid && !err_zero_fs, "R1 reset state",
            {60'b0, in_ready, busy, out_valid, err_zero_fs}, 64'h8);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_op(V_TGT[i], V_FS[i], (i % 3 == 0) ? 3 : 0);

        for (int i = 0; i < 30; i++) begin
            logic [FW-1:0] f;
            f = $urandom;
            if (i % 4 == 0) f = f & 32'h0000_FFFF;
            if (f == 0) f = 1;
            run_op($urandom, f, i % 2);
        end

        // R9 zero target with large rate
        run_op(32'd0, 32'hFFFF_FFFF, 0);

        // R8: zero rate refused
        @(negedge clk);
        in_target = 32'd77;
        in_fs     = '0;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(err_zero_fs && in_ready && !busy, "R8 error pulse",
            {61'b0, err_zero_fs, in_ready, busy}, 64'h6);
        @(negedge clk);
        chk(!err_zero_fs, "R8 error one cycle", 64'(err_zero_fs), 64'h0);
        begin
            bit seen;
            seen = 1'b0;
            repeat (120) begin
                @(negedge clk);
                if (out_valid || busy) seen = 1'b1;
            end
            chk(!seen, "R8 no result", 64'(seen), 64'h0);
        end

        // R1: reset in mid-calculation
        @(negedge clk);
        in_target = 32'd999;
        in_fs     = 32'd10;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(in_ready && !busy && !out_valid && !err_zero_fs, "R1 mid-run reset",
            {60'b0, in_ready, busy, out_valid, err_zero_fs}, 64'h8);

        // R5 half-rate point after reset
        run_op(32'd3000, 32'd2000, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule